// File: doc/BRIEF.md
# Two-Wire DAC Control Slave

This block is the digital front end of a small voltage-output converter. It listens as a slave on a two-wire serial bus and holds an 8-bit converter code and a power-down flag. SCL and SDA are sampled with a fast system clock. Each line passes through a synchronizer and a glitch filter, and the filtered lines are decoded into START, STOP and clock-edge events. The 7-bit slave address is fixed in its upper five bits. The lowest two bits come from strap inputs, so four such slaves can share one bus.

The bit after the address does not select a transfer direction. It carries a power request: 0 means the next byte is a new code and power-down is cleared, and 1 requests power-down while the master clocks a byte out. The new code and power state are held as pending values. They reach the outputs only when a STOP follows a completed second byte. A single-cycle commit pulse marks each update. The block pulls SDA low only in acknowledge slots and otherwise leaves the line released.

Top module: `dac_link_slave`

## Requirements
- R1: After reset the code output is 0x00, power-down is 0, the SDA pull-down is off and the commit pulse is low.
- R2: The slave address is the 7-bit value 0b01100 followed by strap_a1 and then strap_a2, received MSB first. A matching address byte is acknowledged by holding SDA low for the whole high phase of the 9th SCL clock.
- R3: An address byte that does not match, including the general-call value 0x00, gets no acknowledge. It also leaves the code and power state unchanged, even if further bytes and a STOP follow.
- R4: If the 8th address bit is 0, the next byte is taken MSB first as the new code and acknowledged. After the following STOP, the code output equals that byte and power-down is 0.
- R5: A received code does not reach the outputs before the STOP. Between the data acknowledge and the STOP, the code output keeps its old value.
- R6: If the 8th address bit is 1, the slave leaves SDA released for all 8 data clocks and for the 9th clock, so the master reads 0xFF. After the STOP, power-down is 1 and the code is kept.
- R7: A STOP directly after an acknowledged address byte leaves the code and power state unchanged and gives no commit pulse.
- R8: A repeated START after a completed data byte does not commit the pending update. The next STOP does.
- R9: A START or STOP in the middle of a byte abandons the byte and nothing is committed from it. After a START the slave is back in its address phase.
- R10: A pulse on SCL shorter than FILT_CYCLES system clocks (default 3) is not counted as a bus clock.
- R11: Every commit produces exactly one commit pulse, one cycle wide, and no pulse happens without a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_a1 | input | 1 | Address strap, second-lowest address bit |
| strap_a2 | input | 1 | Address strap, lowest address bit |
| dac_code | output | 8 | Committed converter code |
| pwr_down | output | 1 | Committed power-down flag |
| commit_pulse | output | 1 | One-cycle pulse on each commit |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench covers the points where an update could escape early: the interval between the data acknowledge and the STOP, and a repeated START after a full byte. A design that commits on the acknowledge or on the restart shows the new code too soon. STOP directly after the address, mid-byte START and STOP, and unmatched or general-call addresses must all leave the outputs untouched; a slave that commits a half-shifted byte or answers address 0x00 gives a wrong code or an extra pulse. In power-down mode the master must read back 0xFF, which a slave that drives data bits would corrupt. A 2-cycle SCL spike between bits would shift the received code by one bit if the filter let it through.

// File: rtl/dls_pkg.sv
package dls_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_DATA,
      ST_DACK,
      ST_HOLD
   } dls_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } dls_evt_t;

endpackage

// File: rtl/dls_glitch_filter.sv
module dls_glitch_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   FILT_CYCLES = 3,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   localparam int SMSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dls_glitch_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_CYCLES < 0) begin : g_bad_filt
      $error("dls_glitch_filter: FILT_CYCLES must not be negative");
   end

   logic [SMSB:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
      else        sync_q <= {sync_q[SMSB-1:0], line_i};
   end

   if (FILT_CYCLES == 0) begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_o <= IDLE_LEVEL;
         else        line_o <= sync_q[SMSB];
      end
   end else begin : g_count
      localparam int CW = $clog2(FILT_CYCLES + 1);
      localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);
      logic [CW-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q  <= '0;
            line_o <= IDLE_LEVEL;
         end else if (sync_q[SMSB] == line_o) begin
            run_q <= '0;
         end else if (run_q == CNT_LAST) begin
            run_q  <= '0;
            line_o <= sync_q[SMSB];
         end else begin
            run_q <= run_q + 1'b1;
         end
      end

      // R10: the filtered line only takes a value the synchronized input already had
      assert_filter_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (line_o != $past(line_o)) |-> ($past(sync_q[SMSB]) == line_o));
   end

endmodule

// File: rtl/dls_bus_events.sv
module dls_bus_events
   import dls_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_f,
   input  logic     sda_f,
   output dls_evt_t evt
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   always_comb begin
      evt.start = scl_f & scl_q & sda_q & ~sda_f;
      evt.stop  = scl_f & scl_q & ~sda_q & sda_f;
      evt.rise  = scl_f & ~scl_q;
      evt.fall  = ~scl_f & scl_q;
      evt.sda   = sda_f;
   end

endmodule

// File: rtl/dls_frame_ctrl.sv
module dls_frame_ctrl
   import dls_pkg::*;
#(
   parameter int         DATA_W  = 8,
   parameter logic [4:0] ADDR_HI = 5'b01100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dls_evt_t          evt,
   input  logic              strap_a1,
   input  logic              strap_a2,
   output logic              pull_o,
   output logic              load_o,
   output logic              load_code_o,
   output logic              load_pd_o,
   output logic [DATA_W-1:0] load_val_o
);

   localparam int ABITS = 8;
   localparam int CMAX  = (DATA_W > ABITS) ? DATA_W : ABITS;
   localparam int CW    = $clog2(CMAX + 1);
   localparam logic [CW-1:0] A_END = CW'(ABITS);
   localparam logic [CW-1:0] D_END = CW'(DATA_W);

   if (DATA_W < 1) begin : g_bad_w
      $error("dls_frame_ctrl: DATA_W must be at least 1");
   end
   if (ADDR_HI == 5'b0) begin : g_bad_addr
      $error("dls_frame_ctrl: ADDR_HI must be nonzero so general call never matches");
   end

   dls_state_e        st_q;
   logic [CW-1:0]     cnt_q;
   logic [ABITS-1:0]  ash_q;
   logic [DATA_W-1:0] dsh_q;
   logic              rd_q;
   logic [6:0]        my_addr;

   assign my_addr = {ADDR_HI, strap_a1, strap_a2};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cnt_q       <= '0;
         ash_q       <= '0;
         dsh_q       <= '0;
         rd_q        <= 1'b0;
         pull_o      <= 1'b0;
         load_o      <= 1'b0;
         load_code_o <= 1'b0;
         load_pd_o   <= 1'b0;
         load_val_o  <= '0;
      end else begin
         load_o <= 1'b0;
         if (evt.start) begin
            st_q   <= ST_ADDR;
            cnt_q  <= '0;
            pull_o <= 1'b0;
         end else if (evt.stop) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            pull_o <= 1'b0;
         end else begin
            unique case (st_q)
               ST_ADDR: begin
                  if (evt.rise) begin
                     ash_q <= {ash_q[ABITS-2:0], evt.sda};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (evt.fall && cnt_q == A_END) begin
                     if (ash_q[7:1] == my_addr) begin
                        st_q   <= ST_AACK;
                        pull_o <= 1'b1;
                        rd_q   <= ash_q[0];
                     end else begin
                        st_q <= ST_HOLD;
                     end
                  end
               end
               ST_AACK: begin
                  if (evt.fall) begin
                     pull_o <= 1'b0;
                     st_q   <= ST_DATA;
                     cnt_q  <= '0;
                  end
               end
               ST_DATA: begin
                  if (evt.rise) begin
                     if (DATA_W > 1) dsh_q <= {dsh_q[DATA_W-2+((DATA_W>1)?0:1):0], evt.sda};
                     else            dsh_q <= DATA_W'(evt.sda);
                     cnt_q <= cnt_q + 1'b1;
                  end else if (evt.fall && cnt_q == D_END) begin
                     st_q        <= ST_DACK;
                     pull_o      <= ~rd_q;
                     load_o      <= 1'b1;
                     load_code_o <= ~rd_q;
                     load_pd_o   <= rd_q;
                     load_val_o  <= dsh_q;
                  end
               end
               ST_DACK: begin
                  if (evt.fall) begin
                     pull_o <= 1'b0;
                     st_q   <= ST_HOLD;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R6: the pull-down is only ever active in an acknowledge slot
   assert_pull_in_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pull_o |-> (st_q == ST_AACK || st_q == ST_DACK));

   // R6: in power-down (read) mode the data byte and its 9th clock are never driven
   assert_read_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && (st_q == ST_DATA || st_q == ST_DACK)) |-> !pull_o);

   // R3: an address acknowledge only starts for the strapped address
   assert_ack_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_AACK && $rose(pull_o)) |-> (ash_q[7:1] == my_addr));

   // R9: a START always brings the slave back to its address phase
   assert_start_to_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt.start |=> (st_q == ST_ADDR && cnt_q == '0));

endmodule

// File: rtl/dls_commit_reg.sv
module dls_commit_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              load_code_i,
   input  logic              load_pd_i,
   input  logic [DATA_W-1:0] load_val_i,
   input  logic              stop_i,
   output logic [DATA_W-1:0] code_o,
   output logic              pd_o,
   output logic              pulse_o
);

   logic              pend_v_q;
   logic              pend_code_v_q;
   logic              pend_pd_q;
   logic [DATA_W-1:0] pend_val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v_q      <= 1'b0;
         pend_code_v_q <= 1'b0;
         pend_pd_q     <= 1'b0;
         pend_val_q    <= '0;
         code_o        <= '0;
         pd_o          <= 1'b0;
         pulse_o       <= 1'b0;
      end else begin
         pulse_o <= 1'b0;
         if (load_i) begin
            pend_v_q      <= 1'b1;
            pend_code_v_q <= load_code_i;
            pend_pd_q     <= load_pd_i;
            pend_val_q    <= load_val_i;
         end else if (stop_i && pend_v_q) begin
            pend_v_q <= 1'b0;
            pd_o     <= pend_pd_q;
            pulse_o  <= 1'b1;
            if (pend_code_v_q) code_o <= pend_val_q;
         end
      end
   end

   // R4: the code output never moves without a commit pulse
   assert_code_on_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (code_o != $past(code_o)) |-> pulse_o);

   // R6: the power-down flag never moves without a commit pulse
   assert_pd_on_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_o != $past(pd_o)) |-> pulse_o);

   // R5: a commit only follows a STOP
   assert_commit_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> $past(stop_i));

   // R11: the commit pulse is a single cycle
   assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);

endmodule

// File: rtl/dac_link_slave.sv
module dac_link_slave
   import dls_pkg::*;
#(
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_CYCLES = 3,
   parameter logic [4:0] ADDR_HI     = 5'b01100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              strap_a1,
   input  logic              strap_a2,
   output logic [DATA_W-1:0] dac_code,
   output logic              pwr_down,
   output logic              commit_pulse,
   output logic              sda_drive_low
);

   localparam int NLINES = 2;

   logic [NLINES-1:0] raw_lines;
   logic [NLINES-1:0] filt_lines;
   dls_evt_t          evt;
   logic              ld, ld_code, ld_pd;
   logic [DATA_W-1:0] ld_val;

   assign raw_lines = {sda_i, scl_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      dls_glitch_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_CYCLES (FILT_CYCLES),
         .IDLE_LEVEL  (1'b1)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw_lines[g]),
         .line_o (filt_lines[g])
      );
   end

   dls_bus_events u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_f (filt_lines[0]),
      .sda_f (filt_lines[1]),
      .evt   (evt)
   );

   dls_frame_ctrl #(
      .DATA_W  (DATA_W),
      .ADDR_HI (ADDR_HI)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt),
      .strap_a1    (strap_a1),
      .strap_a2    (strap_a2),
      .pull_o      (sda_drive_low),
      .load_o      (ld),
      .load_code_o (ld_code),
      .load_pd_o   (ld_pd),
      .load_val_o  (ld_val)
   );

   dls_commit_reg #(
      .DATA_W (DATA_W)
   ) u_commit (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (ld),
      .load_code_i (ld_code),
      .load_pd_i   (ld_pd),
      .load_val_i  (ld_val),
      .stop_i      (evt.stop),
      .code_o      (dac_code),
      .pd_o        (pwr_down),
      .pulse_o     (commit_pulse)
   );

endmodule

// File: tb/tb_dac_link_slave.sv
module tb_dac_link_slave;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       a1 = 1'b1;
   logic       a2 = 1'b0;
   logic [7:0] dac_code;
   logic       pwr_down, commit_pulse, sda_drive_low;
   logic       sda_line;

   int n_chk = 0;
   int n_fail = 0;
   logic [8:0] exp_q[$];
   logic       pulse_prev = 1'b0;

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_drive_low;

   dac_link_slave dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl_m),
      .sda_i         (sda_line),
      .strap_a1      (a1),
      .strap_a2      (a2),
      .dac_code      (dac_code),
      .pwr_down      (pwr_down),
      .commit_pulse  (commit_pulse),
      .sda_drive_low (sda_drive_low)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: each commit pulse pops one expected {pwr_down, code}
   always @(negedge clk) begin
      if (rst_n) begin
         if (commit_pulse && pulse_prev) begin
            n_chk++; n_fail++;
            $display("FAIL R11 pulse width actual=2+ expected=1");
         end
         if (commit_pulse) begin
            if (exp_q.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R11 unexpected commit actual=%0h expected=none", {pwr_down, dac_code});
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk("R11 scoreboard commit", {23'd0, pwr_down, dac_code}, {23'd0, e});
            end
         end
         pulse_prev <= commit_pulse;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(2*Q);
      scl_m = 1'b1; tick(2*Q);
      sda_m = 1'b0; tick(2*Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(2*Q);
      scl_m = 1'b1; tick(2*Q);
      sda_m = 1'b1; tick(4*Q);
   endtask

   task automatic bus_bit(input logic b, output logic seen);
      sda_m = b;    tick(2*Q);
      scl_m = 1'b1; tick(Q);
      seen = sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input int glitch_at,
                            output logic ack, output logic [7:0] rd);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         if (i == glitch_at) begin
            scl_m = 1'b1; tick(2);
            scl_m = 1'b0; tick(Q);
         end
         bus_bit(b[i], s);
         rd[i] = s;
      end
      bus_bit(1'b1, s);
      ack = ~s;
   endtask

   initial begin
      logic       ack;
      logic [7:0] rd;
      logic       s;
      tick(5);
      // R1 reset state
      chk("R1 code", {24'd0, dac_code}, 32'h00);
      chk("R1 pwr_down", {31'd0, pwr_down}, 0);
      chk("R1 sda pull", {31'd0, sda_drive_low}, 0);
      chk("R1 pulse", {31'd0, commit_pulse}, 0);
      rst_n = 1'b1;
      tick(10);

      // R2 / R4 / R5: write 0xA5 to address byte 0x64 (A1=1, A2=0)
      bus_start();
      send_byte(8'h64, -1, ack, rd); chk("R2 address ack", {31'd0, ack}, 1);
      send_byte(8'hA5, -1, ack, rd); chk("R4 data ack", {31'd0, ack}, 1);
      tick(Q);
      chk("R5 code held before STOP", {24'd0, dac_code}, 32'h00);
      exp_q.push_back({1'b0, 8'hA5});
      bus_stop();
      chk("R4 code after STOP", {24'd0, dac_code}, 32'hA5);
      chk("R4 pwr_down after write", {31'd0, pwr_down}, 0);

      // R3: non-matching address 0x66
      bus_start();
      send_byte(8'h66, -1, ack, rd); chk("R3 foreign address nack", {31'd0, ack}, 0);
      send_byte(8'h12, -1, ack, rd); chk("R3 foreign data nack", {31'd0, ack}, 0);
      bus_stop();
      chk("R3 code unchanged", {24'd0, dac_code}, 32'hA5);

      // R3: general call
      bus_start();
      send_byte(8'h00, -1, ack, rd); chk("R3 general call nack", {31'd0, ack}, 0);
      bus_stop();
      chk("R3 code after general call", {24'd0, dac_code}, 32'hA5);

      // R6: power-down request (8th bit = 1)
      bus_start();
      send_byte(8'h65, -1, ack, rd); chk("R6 address ack", {31'd0, ack}, 1);
      send_byte(8'hFF, -1, ack, rd);
      chk("R6 read byte all ones", {24'd0, rd}, 32'hFF);
      chk("R6 no ack driven after read byte", {31'd0, ack}, 0);
      exp_q.push_back({1'b1, 8'hA5});
      bus_stop();
      chk("R6 pwr_down set", {31'd0, pwr_down}, 1);
      chk("R6 code kept", {24'd0, dac_code}, 32'hA5);

      // R4: write clears power-down
      bus_start();
      send_byte(8'h64, -1, ack, rd);
      send_byte(8'h3C, -1, ack, rd);
      exp_q.push_back({1'b0, 8'h3C});
      bus_stop();
      chk("R4 code 3C", {24'd0, dac_code}, 32'h3C);
      chk("R4 pwr_down cleared", {31'd0, pwr_down}, 0);

      // R7: STOP right after an acknowledged address (power-down bit set)
      bus_start();
      send_byte(8'h65, -1, ack, rd); chk("R7 address ack", {31'd0, ack}, 1);
      bus_stop();
      chk("R7 pwr_down unchanged", {31'd0, pwr_down}, 0);
      chk("R7 code unchanged", {24'd0, dac_code}, 32'h3C);

      // R8: repeated START does not commit; the next STOP does
      bus_start();
      send_byte(8'h64, -1, ack, rd);
      send_byte(8'h11, -1, ack, rd); chk("R8 data ack", {31'd0, ack}, 1);
      bus_start();
      tick(Q);
      chk("R8 code held over restart", {24'd0, dac_code}, 32'h3C);
      exp_q.push_back({1'b0, 8'h11});
      bus_stop();
      chk("R8 code after STOP", {24'd0, dac_code}, 32'h11);

      // R9: STOP in the middle of the data byte
      bus_start();
      send_byte(8'h64, -1, ack, rd);
      bus_bit(1'b1, s); bus_bit(1'b0, s); bus_bit(1'b1, s); bus_bit(1'b0, s);
      bus_stop();
      chk("R9 mid-byte STOP no commit", {24'd0, dac_code}, 32'h11);

      // R9: START in the middle of the data byte, then a full write
      bus_start();
      send_byte(8'h64, -1, ack, rd);
      bus_bit(1'b0, s); bus_bit(1'b1, s); bus_bit(1'b1, s);
      bus_start();
      send_byte(8'h64, -1, ack, rd); chk("R9 address ack after restart", {31'd0, ack}, 1);
      send_byte(8'h77, -1, ack, rd);
      exp_q.push_back({1'b0, 8'h77});
      bus_stop();
      chk("R9 code after aborted byte", {24'd0, dac_code}, 32'h77);

      // R2 / R3: new straps A1=0, A2=1 give address byte 0x62
      a1 = 1'b0; a2 = 1'b1;
      tick(Q);
      bus_start();
      send_byte(8'h64, -1, ack, rd); chk("R3 old address nack", {31'd0, ack}, 0);
      bus_stop();
      chk("R3 code after old address", {24'd0, dac_code}, 32'h77);

      // R10: 2-cycle SCL spike inside the data byte is not a clock
      bus_start();
      send_byte(8'h62, -1, ack, rd); chk("R2 new strap address ack", {31'd0, ack}, 1);
      send_byte(8'hC3, 4, ack, rd);  chk("R10 data ack with spike", {31'd0, ack}, 1);
      exp_q.push_back({1'b0, 8'hC3});
      bus_stop();
      chk("R10 code with spike", {24'd0, dac_code}, 32'hC3);

      tick(20);
      chk("R11 all expected commits seen", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule